// File: doc/BRIEF.md
# Flyback Discharge-Time Sampler with Current-Limit and Burst Mode Selection

This block sits in the digital core of a primary-side regulated flyback controller. After every gate turn-off it counts clock cycles while the secondary diode conducts, using a digitized code of the auxiliary-winding voltage. At a fixed fraction of the discharge time measured in the previous switching cycle it captures that code into a hold register. It then declares the end of conduction (a zero-crossing event) when the live code falls far enough below the held code. The counted interval becomes the new discharge time, and it also sets the sample point for the next cycle.

The held code drives two decisions. The first is a current-limit select with hysteresis: low threshold when the output is collapsed, normal threshold once it recovers. The second is a switching period word that stretches linearly as the held code falls, which keeps a shorted or overloaded output in discontinuous conduction. A second code, the digitized feedback voltage, runs a hysteretic comparator that gates switching on and off at light load (burst operation). The voltage converters are outside the block.

Voltage codes are unsigned with 5 mV per LSB. Frequencies are internally in units of 10 Hz, and the clock is 100 MHz.

Top module: `aux_dis_ctrl`

## Requirements
- R1: After reset: tdis_o = 0, zcd_o = 0, plim_lo_o = 1 (low current limit selected), period_o = 1176 (nominal 85 kHz), sw_en_o = 1.
- R2: When gate_off_i is sampled high at edge E0, the cycle counter starts at 0 and increments each edge. If the first edge that sees a valid zero-crossing is E(d+1), then zcd_o is high for exactly one cycle after that edge, and tdis_o = d in the same cycle. tdis_o changes at no other time.
- R3: The hold sample is taken at the edge where the counter equals (prev × 217) >> 8, where prev is the last valid discharge time. Before the first valid measurement, prev is 64, which gives a sample point of 54.
- R4: A zero-crossing requires held − vs_code_i > 40 (200 mV). A drop of exactly 40 codes produces no event.
- R5: A drop that occurs before the sample instant is not detected. The sample then holds the already-low code, and no event follows.
- R6: A gate_on_i pulse during a measurement with no zero-crossing discards that measurement. tdis_o and prev stay unchanged, and no zcd_o pulse occurs.
- R7: At each new sample, plim_lo_o is set if held < 110 (0.55 V) and cleared if held > 150 (0.75 V). Otherwise it keeps its value.
- R8: After each new sample, within 30 cycles, period_o = 10,000,000 / f (truncated). Here f = 8500 when held ≥ 430. Otherwise f = 8500 − 19 × (430 − max(held, 140)), with a floor of 2600.
- R9: sw_en_o clears one edge after fb_code_i < 260 (1.3 V) and sets one edge after fb_code_i > 300 (1.5 V). Codes in between leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_off_i | input | 1 | One-cycle pulse at gate turn-off; starts a measurement |
| gate_on_i | input | 1 | One-cycle pulse at gate turn-on; aborts an open measurement |
| vs_code_i | input | 10 | Auxiliary-winding voltage code, 5 mV/LSB |
| fb_code_i | input | 10 | Feedback voltage code, 5 mV/LSB |
| tdis_o | output | 12 | Last valid discharge time in clock cycles |
| zcd_o | output | 1 | One-cycle zero-crossing pulse |
| plim_lo_o | output | 1 | 1 selects the low (0.3 V) current limit, 0 the normal (0.8 V) limit |
| period_o | output | 16 | Switching period in clock cycles |
| sw_en_o | output | 1 | Switching enable from the feedback hysteresis |

## Verification
The bench places the voltage drop exactly one cycle after the computed sample point. A design that put the sample point even one count late would miss that event. It also applies a drop of exactly 40 codes, which a design with an off-by-one comparison would wrongly report as a zero-crossing, and a drop that comes before the sample instant, which a detector working on a fixed threshold would report. An aborted measurement must leave tdis_o untouched. The held code is walked through both hysteresis bands and into the low-voltage clamp of the frequency curve, so a design without the clamp or without the hold band would give a wrong period or select flag. The feedback comparator is driven to exactly 260 and 300, where a design using inclusive comparisons would toggle.

// File: rtl/aux_dis_pkg.sv
package aux_dis_pkg;
   // Which side of the hysteresis band drives the output high
   typedef enum logic {
      HYS_HIGH_ACTIVE = 1'b0,
      HYS_LOW_ACTIVE  = 1'b1
   } hys_pol_e;
endpackage

// File: rtl/aux_hyst.sv
module aux_hyst #(
   parameter int                   W      = 10,
   parameter int                   LO     = 110,
   parameter int                   HI     = 150,
   parameter aux_dis_pkg::hys_pol_e POL   = aux_dis_pkg::HYS_HIGH_ACTIVE,
   parameter bit                   RST_LV = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] x,
   output logic         y
);
   if (LO >= HI) begin : g_bad_band
      $error("aux_hyst: LO must be below HI");
   end
   if (HI >= (1 << W)) begin : g_bad_width
      $error("aux_hyst: HI does not fit in W bits");
   end

   localparam logic [W-1:0] LO_C = W'(LO);
   localparam logic [W-1:0] HI_C = W'(HI);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= RST_LV;
      end else if (upd) begin
         if (x > HI_C)      lvl_q <= 1'b1;
         else if (x < LO_C) lvl_q <= 1'b0;
      end
   end

   if (POL == aux_dis_pkg::HYS_LOW_ACTIVE) begin : g_inv
      assign y = ~lvl_q;
   end else begin : g_dir
      assign y = lvl_q;
   end

   // R7 R9
   level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_q) |-> $past(upd && (x > HI_C)));
   // R7 R9
   level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl_q) |-> $past(upd && (x < LO_C)));
endmodule

// File: rtl/aux_dis_timer.sv
module aux_dis_timer #(
   parameter int VW      = 10,
   parameter int TW      = 12,
   parameter int TDEF    = 64,
   parameter int DROP    = 40,
   parameter int SMP_NUM = 217,
   parameter int SMP_SH  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_off_i,
   input  logic          gate_on_i,
   input  logic [VW-1:0] vs_i,
   output logic [TW-1:0] tdis_o,
   output logic          zcd_o,
   output logic [VW-1:0] held_o,
   output logic          hstb_o
);
   if (SMP_NUM >= (1 << SMP_SH)) begin : g_bad_frac
      $error("aux_dis_timer: sample fraction must be below one");
   end
   if (TDEF >= (1 << TW)) begin : g_bad_def
      $error("aux_dis_timer: default time does not fit TW");
   end

   localparam int            PRW    = TW + SMP_SH;
   localparam logic [TW-1:0] CNT_MX = '1;
   localparam logic [VW-1:0] DROP_C = VW'(DROP);

   logic          meas_q, hvld_q, zcd_q, hstb_q;
   logic [TW-1:0] cnt_q, prev_q, tdis_q;
   logic [VW-1:0] held_q;
   logic [PRW-1:0] prod;
   logic [TW-1:0]  spt;
   logic           drop_hit;

   assign prod     = PRW'(prev_q) * PRW'(SMP_NUM);
   assign spt      = prod[SMP_SH +: TW];
   assign drop_hit = (held_q > vs_i) && ((held_q - vs_i) > DROP_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_q <= 1'b0;
         hvld_q <= 1'b0;
         zcd_q  <= 1'b0;
         hstb_q <= 1'b0;
         cnt_q  <= '0;
         prev_q <= TW'(TDEF);
         tdis_q <= '0;
         held_q <= '0;
      end else begin
         zcd_q  <= 1'b0;
         hstb_q <= 1'b0;
         if (gate_off_i) begin
            meas_q <= 1'b1;
            hvld_q <= 1'b0;
            cnt_q  <= '0;
         end else if (meas_q) begin
            if (gate_on_i) begin
               meas_q <= 1'b0;
            end else begin
               if (cnt_q != CNT_MX) cnt_q <= cnt_q + 1'b1;
               if (!hvld_q && (cnt_q == spt)) begin
                  held_q <= vs_i;
                  hvld_q <= 1'b1;
                  hstb_q <= 1'b1;
               end else if (hvld_q && drop_hit) begin
                  zcd_q  <= 1'b1;
                  tdis_q <= cnt_q;
                  prev_q <= cnt_q;
                  meas_q <= 1'b0;
               end
            end
         end
      end
   end

   assign tdis_o = tdis_q;
   assign zcd_o  = zcd_q;
   assign held_o = held_q;
   assign hstb_o = hstb_q;

   // R2
   zcd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_q |=> !zcd_q);
   // R2
   tdis_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zcd_q |-> $stable(tdis_q));
   // R5
   zcd_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_q |-> $past(hvld_q));
   // R3
   hold_in_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hstb_q |-> $past(meas_q));
endmodule

// File: rtl/aux_freq_period.sv
module aux_freq_period #(
   parameter int VW       = 10,
   parameter int PW       = 16,
   parameter int CC_HI    = 430,
   parameter int CC_LO    = 140,
   parameter int F_NOM    = 8500,
   parameter int F_SLOPE  = 19,
   parameter int F_MIN    = 2600,
   parameter int CLK_DKHZ = 10_000_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [VW-1:0] held,
   output logic [PW-1:0] period_o
);
   if (F_MIN <= 0 || F_MIN > F_NOM) begin : g_bad_fmin
      $error("aux_freq_period: F_MIN out of range");
   end
   if (CC_LO >= CC_HI) begin : g_bad_cc
      $error("aux_freq_period: CC_LO must be below CC_HI");
   end

   localparam int             FW      = $clog2(F_NOM + 1);
   localparam int             DVW     = $clog2(CLK_DKHZ + 1);
   localparam int             CW      = $clog2(DVW + 1);
   localparam logic [PW-1:0]  PER_RST = PW'(CLK_DKHZ / F_NOM);

   int            he, fi;
   logic [FW-1:0] fcalc;

   always_comb begin
      he = (int'(held) < CC_LO) ? CC_LO : int'(held);
      if (int'(held) >= CC_HI) fi = F_NOM;
      else                     fi = F_NOM - F_SLOPE * (CC_HI - he);
      if (fi < F_MIN) fi = F_MIN;
      fcalc = FW'(fi);
   end

   logic [FW:0]    rem_q, rem_sh, rem_nx;
   logic [DVW-1:0] dvd_q, quo_q, quo_nx;
   logic [FW-1:0]  dsr_q;
   logic [CW-1:0]  cnt_q;
   logic           busy_q, ge;
   logic [PW-1:0]  per_q;

   assign rem_sh = {rem_q[FW-1:0], dvd_q[DVW-1]};
   assign ge     = rem_sh >= {1'b0, dsr_q};
   assign rem_nx = ge ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
   assign quo_nx = {quo_q[DVW-2:0], ge};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dvd_q  <= '0;
         quo_q  <= '0;
         dsr_q  <= FW'(F_NOM);
         cnt_q  <= '0;
         busy_q <= 1'b0;
         per_q  <= PER_RST;
      end else if (start) begin
         rem_q  <= '0;
         dvd_q  <= DVW'(CLK_DKHZ);
         quo_q  <= '0;
         dsr_q  <= fcalc;
         cnt_q  <= CW'(DVW);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         rem_q <= rem_nx;
         dvd_q <= dvd_q << 1;
         quo_q <= quo_nx;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            if (quo_nx >= DVW'(1 << PW)) per_q <= '1;
            else                         per_q <= quo_nx[PW-1:0];
         end
      end
   end

   assign period_o = per_q;

   // R8
   period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (cnt_q != CW'(1))) |=> $stable(per_q));
endmodule

// File: rtl/aux_dis_ctrl.sv
module aux_dis_ctrl #(
   parameter int VW       = 10,
   parameter int TW       = 12,
   parameter int PW       = 16,
   parameter int TDEF     = 64,
   parameter int DROP     = 40,
   parameter int SMP_NUM  = 217,
   parameter int SMP_SH   = 8,
   parameter int PL_LO    = 110,
   parameter int PL_HI    = 150,
   parameter int CC_HI    = 430,
   parameter int CC_LO    = 140,
   parameter int F_NOM    = 8500,
   parameter int F_SLOPE  = 19,
   parameter int F_MIN    = 2600,
   parameter int CLK_DKHZ = 10_000_000,
   parameter int FB_LO    = 260,
   parameter int FB_HI    = 300
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_off_i,
   input  logic          gate_on_i,
   input  logic [VW-1:0] vs_code_i,
   input  logic [VW-1:0] fb_code_i,
   output logic [TW-1:0] tdis_o,
   output logic          zcd_o,
   output logic          plim_lo_o,
   output logic [PW-1:0] period_o,
   output logic          sw_en_o
);
   logic [VW-1:0] held;
   logic          hstb;

   aux_dis_timer #(
      .VW(VW), .TW(TW), .TDEF(TDEF), .DROP(DROP),
      .SMP_NUM(SMP_NUM), .SMP_SH(SMP_SH)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .gate_off_i(gate_off_i), .gate_on_i(gate_on_i),
      .vs_i(vs_code_i), .tdis_o(tdis_o), .zcd_o(zcd_o),
      .held_o(held), .hstb_o(hstb)
   );

   aux_hyst #(
      .W(VW), .LO(PL_LO), .HI(PL_HI),
      .POL(aux_dis_pkg::HYS_LOW_ACTIVE), .RST_LV(1'b0)
   ) u_plim (
      .clk(clk), .rst_n(rst_n), .upd(hstb), .x(held), .y(plim_lo_o)
   );

   aux_freq_period #(
      .VW(VW), .PW(PW), .CC_HI(CC_HI), .CC_LO(CC_LO), .F_NOM(F_NOM),
      .F_SLOPE(F_SLOPE), .F_MIN(F_MIN), .CLK_DKHZ(CLK_DKHZ)
   ) u_per (
      .clk(clk), .rst_n(rst_n), .start(hstb), .held(held), .period_o(period_o)
   );

   aux_hyst #(
      .W(VW), .LO(FB_LO), .HI(FB_HI),
      .POL(aux_dis_pkg::HYS_HIGH_ACTIVE), .RST_LV(1'b1)
   ) u_burst (
      .clk(clk), .rst_n(rst_n), .upd(1'b1), .x(fb_code_i), .y(sw_en_o)
   );

   // R6
   abort_no_zcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && !gate_off_i) |=> !zcd_o);
endmodule

// File: tb/sim_aux_dis_ctrl.sv
`timescale 1ns/1ps
module sim_aux_dis_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate_off_i = 1'b0;
   logic        gate_on_i = 1'b0;
   logic [9:0]  vs_code_i = '0;
   logic [9:0]  fb_code_i = 10'd500;
   logic [11:0] tdis_o;
   logic        zcd_o;
   logic        plim_lo_o;
   logic [15:0] period_o;
   logic        sw_en_o;

   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   aux_dis_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .gate_off_i(gate_off_i), .gate_on_i(gate_on_i),
      .vs_code_i(vs_code_i), .fb_code_i(fb_code_i), .tdis_o(tdis_o),
      .zcd_o(zcd_o), .plim_lo_o(plim_lo_o), .period_o(period_o), .sw_en_o(sw_en_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_period(input int h);
      int he, f;
      he = (h < 140) ? 140 : h;
      f  = (h >= 430) ? 8500 : 8500 - 19 * (430 - he);
      if (f < 2600) f = 2600;
      return 10_000_000 / f;
   endfunction

   // monitor: pops expected discharge times as zero-crossings appear
   always @(negedge clk) begin
      if (rst_n && zcd_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5/R6 unexpected zcd", int'(tdis_o), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(tdis_o) == e, "R2 tdis", int'(tdis_o), e);
         end
      end
   end

   // driver: gate-off, optional first drop, then a final drop
   task automatic cycle_run(input int vhi, input int d1, input int v1,
                            input int extra, input int v2);
      exp_q.push_back(d1 + extra);
      @(negedge clk); gate_off_i = 1'b1; vs_code_i = 10'(vhi);
      @(posedge clk);
      @(negedge clk); gate_off_i = 1'b0;
      repeat (d1) @(posedge clk);
      @(negedge clk); vs_code_i = 10'(v1);
      if (extra > 0) begin
         repeat (extra) @(posedge clk);
         @(negedge clk); vs_code_i = 10'(v2);
      end
      repeat (40) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tdis_o == 0, "R1 tdis", int'(tdis_o), 0);
      chk(zcd_o == 0, "R1 zcd", int'(zcd_o), 0);
      chk(plim_lo_o == 1, "R1 plim", int'(plim_lo_o), 1);
      chk(period_o == 1176, "R1 period", int'(period_o), 1176);
      chk(sw_en_o == 1, "R1 sw_en", int'(sw_en_o), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 default sample point 54; R2 tdis 80; R7 clear; R8 nominal
      cycle_run(600, 80, 559, 0, 0);
      chk(plim_lo_o == 0, "R7 clear above 150", int'(plim_lo_o), 0);
      chk(int'(period_o) == exp_period(600), "R8 period 600", int'(period_o), exp_period(600));

      // R4 drop of exactly 40 ignored, 41 detected five cycles later
      cycle_run(400, 120, 360, 5, 359);
      chk(int'(period_o) == exp_period(400), "R8 period 400", int'(period_o), exp_period(400));

      // R5 early drop before sample point 105; R6 abort by gate-on
      @(negedge clk); gate_off_i = 1'b1; vs_code_i = 10'd300;
      @(posedge clk);
      @(negedge clk); gate_off_i = 1'b0;
      repeat (50) @(posedge clk);
      @(negedge clk); vs_code_i = 10'd200;
      repeat (100) @(posedge clk);
      @(negedge clk); gate_on_i = 1'b1;
      @(posedge clk);
      @(negedge clk); gate_on_i = 1'b0;
      repeat (40) @(negedge clk);
      chk(tdis_o == 125, "R6 tdis kept", int'(tdis_o), 125);
      chk(int'(period_o) == exp_period(200), "R5 held low code 200", int'(period_o), exp_period(200));

      // R3 prev kept at 125: sample point 105, drop right after it; R7 set below 110
      cycle_run(100, 106, 59, 0, 0);
      chk(plim_lo_o == 1, "R7 set below 110", int'(plim_lo_o), 1);
      chk(int'(period_o) == exp_period(100), "R8 clamp 100", int'(period_o), exp_period(100));

      // R7 inside band holds; R8 clamp at 140
      cycle_run(130, 90, 89, 0, 0);
      chk(plim_lo_o == 1, "R7 band hold", int'(plim_lo_o), 1);
      chk(period_o == 3344, "R8 clamp 130", int'(period_o), 3344);

      // R7 recover above 150; R3 sample point 76
      cycle_run(160, 77, 119, 0, 0);
      chk(plim_lo_o == 0, "R7 clear 160", int'(plim_lo_o), 0);
      chk(int'(period_o) == exp_period(160), "R8 period 160", int'(period_o), exp_period(160));

      // R9 feedback hysteresis
      @(negedge clk); fb_code_i = 10'd260;
      @(negedge clk); chk(sw_en_o == 1, "R9 at 260 hold", int'(sw_en_o), 1);
      fb_code_i = 10'd259;
      @(negedge clk); chk(sw_en_o == 0, "R9 below 260", int'(sw_en_o), 0);
      fb_code_i = 10'd300;
      @(negedge clk); chk(sw_en_o == 0, "R9 at 300 hold", int'(sw_en_o), 0);
      fb_code_i = 10'd301;
      @(negedge clk); chk(sw_en_o == 1, "R9 above 300", int'(sw_en_o), 1);

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R2 missing zcd", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule